// File: doc/BRIEF.md
# DMA transfer error monitor

This block follows the transfer errors of a DMA engine that serves several requests. The transfer engine reports each failed transfer with a one-cycle event. The event carries a 3-bit status code and the number of the request that failed. A code of zero means "no error".

The block keeps the full details of the first error. A later error from another request raises a sticky double-error flag, and its details are thrown away. Anything after that is not recorded.

When the error-stop enable input is high, an error also freezes the engine. New transfers are then not permitted to start. Requests that arrive during the freeze are still collected in a per-request pending vector. Acknowledges from the arbiter cannot remove them. The freeze, the held error details and the interrupt all end when software writes the clear value to the command port. The pending requests are then served in the normal way.

Top module: `dma_err_monitor`

## Requirements
- R1: After reset the status code reads 000, the stored request number is 0, the double-error flag is 0, the stop flag is 0, the interrupt is 0, no request is pending and the start permit is 1.
- R2: An error event with a non-zero code that arrives while the status code is 000 stores its code and request number. Both values are visible right after the clock edge that sampled the event.
- R3: An error event with a non-zero code from a request number different from the stored one sets the double-error flag when an error is already held. The stored code and request number are kept.
- R4: Once the double-error flag is set, further error events change none of the status outputs. While an error is held, an error event from the same request number changes nothing.
- R5: An error event whose code is 000 has no effect on any status output.
- R6: When the stop enable is 1 at the edge that samples any error event with a non-zero code, the stop flag becomes 1. The start permit output is the inverse of the stop flag.
- R7: While the stop flag is 1, a request pulse on any bit still sets that pending bit, and acknowledges leave all pending bits unchanged.
- R8: The interrupt output is 1 exactly while the status code is non-zero.
- R9: A command write with the value 0xA5 is sampled at edge k. Edge k+1 then clears the status code, request number, double-error flag and stop flag. A write with any other value has no effect.
- R10: A new error event can arrive at the same edge at which a clear takes effect. It is then stored as a first error, the double-error flag is 0, and the stop flag equals the stop enable.
- R11: While the stop flag is 0, an acknowledge bit clears its pending bit at the next edge. A request pulse on the same bit in the same cycle keeps the bit set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_stop_en | input | 1 | Enables entry into the stop state on error |
| err_valid | input | 1 | Error event strobe from the transfer engine |
| err_code | input | 3 | Error status code of the event (000 = none) |
| err_req | input | ID_W (3) | Request number of the failed transfer |
| cmd_wr | input | 1 | Command write strobe |
| cmd_data | input | 8 | Command write value (0xA5 = error clear) |
| req_in | input | NUM_REQ (8) | Incoming transfer request pulses |
| req_ack | input | NUM_REQ (8) | Arbiter acknowledges, one per request |
| sts_code | output | 3 | Held error status code |
| sts_req | output | ID_W (3) | Request number of the first error |
| sts_double | output | 1 | Sticky double-error flag |
| sts_estop | output | 1 | Stop state flag |
| err_irq | output | 1 | Error interrupt |
| start_ok | output | 1 | New transfers may start |
| req_pend | output | NUM_REQ (8) | Pending request vector |

## Verification
Error events, request pulses and acknowledges sampled at one edge show up on the outputs right after that same edge. A clear write needs one more edge before the status outputs drop, because the command goes through a register first. The bench drives its inputs on the falling edge. Its reference model advances on each rising edge, and every output is compared on the next falling edge, so each result is read in the cycle in which it becomes due. Directed checks also read the outputs one falling edge after a clear write and confirm that the status is still held there.

// File: rtl/dma_err_pkg.sv
// Package: shared widths, types and the clear command value for the
// DMA transfer error monitor. Assumes a 3-bit error code and 8-bit command.
package dma_err_pkg;
    localparam int CODE_W = 3;
    localparam int CMD_W  = 8;
    localparam logic [CMD_W-1:0] CLR_CMD_DEFAULT = 8'hA5;

    typedef logic [CODE_W-1:0] err_code_t;
    typedef logic [CMD_W-1:0]  cmd_t;

    // Held error record
    typedef struct packed {
        err_code_t code;
        logic      dbl;
        logic      stop;
    } err_flags_t;
endpackage

// File: rtl/dem_cmd_decode.sv
// Module: command decoder. Registers a strobe when the clear value is
// written, so the clear acts one cycle after the write.
// Assumes cmd_data is valid whenever cmd_wr is high.
module dem_cmd_decode
    import dma_err_pkg::*;
#(
    parameter cmd_t CLR_CMD = CLR_CMD_DEFAULT
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_wr,
    input  cmd_t cmd_data,
    output logic clr_pend
);
    logic hit;

    // Match the write against the clear value
    always_comb begin
        hit = cmd_wr && (cmd_data == CLR_CMD);
    end

    // Delay the match by one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clr_pend <= 1'b0;
        end else begin
            clr_pend <= hit;
        end
    end
endmodule

// File: rtl/dem_err_capture.sv
// Module: error capture. Stores the first error in full, flags a second
// error from another request, ignores all later ones, and tracks the stop
// state. A clear at the same edge as a new event yields a fresh first error.
// Assumes err_req stays within the number of requests served.
module dem_err_capture
    import dma_err_pkg::*;
#(
    parameter int ID_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_stop_en,
    input  logic            err_valid,
    input  err_code_t       err_code,
    input  logic [ID_W-1:0] err_req,
    input  logic            clr_pend,
    output err_flags_t      flags,
    output logic [ID_W-1:0] first_req
);
    logic       evt;
    logic       held;
    err_flags_t flags_nx;
    logic [ID_W-1:0] req_nx;

    // Qualify the event: a zero code is not an error
    always_comb begin
        evt  = err_valid && (err_code != '0);
        held = (flags.code != '0);
    end

    // Next-state selection for the error record
    always_comb begin
        flags_nx = flags;
        req_nx   = first_req;
        if (clr_pend) begin
            flags_nx.dbl  = 1'b0;
            flags_nx.stop = evt && cfg_stop_en;
            flags_nx.code = evt ? err_code : '0;
            req_nx        = evt ? err_req : '0;
        end else if (evt) begin
            if (!held) begin
                flags_nx.code = err_code;
                req_nx        = err_req;
            end else if (!flags.dbl && (err_req != first_req)) begin
                flags_nx.dbl = 1'b1;
            end
            if (cfg_stop_en) begin
                flags_nx.stop = 1'b1;
            end
        end
    end

    // Error record registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags     <= '0;
            first_req <= '0;
        end else begin
            flags     <= flags_nx;
            first_req <= req_nx;
        end
    end
endmodule

// File: rtl/dem_req_hold.sv
// Module: request holding. One pending bit per request. A pulse sets its
// bit; an acknowledge clears it only when not frozen. A set in the same
// cycle as a clear wins. Assumes at most one pulse per request per cycle.
module dem_req_hold #(
    parameter int NUM_REQ = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               freeze,
    input  logic [NUM_REQ-1:0] req_in,
    input  logic [NUM_REQ-1:0] req_ack,
    output logic [NUM_REQ-1:0] req_pend
);
    for (genvar g = 0; g < NUM_REQ; g++) begin : g_bit
        logic drop;

        // Acknowledges act only outside the frozen state
        always_comb begin
            drop = req_ack[g] && !freeze;
        end

        // Pending flag for request g
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                req_pend[g] <= 1'b0;
            end else begin
                req_pend[g] <= req_in[g] || (req_pend[g] && !drop);
            end
        end
    end
endmodule

// File: rtl/dma_err_monitor.sv
// Module: DMA transfer error monitor top. Ties the command decoder, the
// error capture and the request holding together and drives the status
// readout, interrupt and start permit. Assumes one error event per cycle.
module dma_err_monitor
    import dma_err_pkg::*;
#(
    parameter int   NUM_REQ = 8,
    parameter cmd_t CLR_CMD = CLR_CMD_DEFAULT,
    localparam int  ID_W    = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_stop_en,
    input  logic               err_valid,
    input  logic [CODE_W-1:0]  err_code,
    input  logic [ID_W-1:0]    err_req,
    input  logic               cmd_wr,
    input  logic [CMD_W-1:0]   cmd_data,
    input  logic [NUM_REQ-1:0] req_in,
    input  logic [NUM_REQ-1:0] req_ack,
    output logic [CODE_W-1:0]  sts_code,
    output logic [ID_W-1:0]    sts_req,
    output logic               sts_double,
    output logic               sts_estop,
    output logic               err_irq,
    output logic               start_ok,
    output logic [NUM_REQ-1:0] req_pend
);
    logic       clr_pend;
    err_flags_t flags;

    dem_cmd_decode #(.CLR_CMD(CLR_CMD)) i_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_wr   (cmd_wr),
        .cmd_data (cmd_data),
        .clr_pend (clr_pend)
    );

    dem_err_capture #(.ID_W(ID_W)) i_cap (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_stop_en (cfg_stop_en),
        .err_valid   (err_valid),
        .err_code    (err_code),
        .err_req     (err_req),
        .clr_pend    (clr_pend),
        .flags       (flags),
        .first_req   (sts_req)
    );

    dem_req_hold #(.NUM_REQ(NUM_REQ)) i_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .freeze   (flags.stop),
        .req_in   (req_in),
        .req_ack  (req_ack),
        .req_pend (req_pend)
    );

    // Status readout, interrupt and start permit
    always_comb begin
        sts_code   = flags.code;
        sts_double = flags.dbl;
        sts_estop  = flags.stop;
        err_irq    = (flags.code != '0);
        start_ok   = !flags.stop;
    end
endmodule

// File: rtl/dem_checker.sv
// Module: assertion checker for the error monitor, bound to the top.
// Assumes the synchronous active-low reset of the top.
module dem_checker #(
    parameter int NUM_REQ = 8,
    parameter int ID_W    = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cfg_stop_en,
    input logic               err_valid,
    input logic [2:0]         err_code,
    input logic [ID_W-1:0]    err_req,
    input logic               clr_pend,
    input logic [2:0]         sts_code,
    input logic [ID_W-1:0]    sts_req,
    input logic               sts_double,
    input logic               sts_estop,
    input logic [NUM_REQ-1:0] req_pend
);
    p_first_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (err_valid && err_code != 3'b000 && sts_code == 3'b000)
        |=> (sts_code == $past(err_code) && sts_req == $past(err_req)));

    p_details_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_code != 3'b000 && !clr_pend)
        |=> ($stable(sts_code) && $stable(sts_req)));

    p_double_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_double && !clr_pend) |=> sts_double);

    p_zero_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_pend && (!err_valid || err_code == 3'b000))
        |=> ($stable(sts_code) && $stable(sts_double) && $stable(sts_estop)));

    p_stop_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_stop_en && err_valid && err_code != 3'b000) |=> sts_estop);

    p_frozen_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sts_estop |=> ((req_pend & $past(req_pend)) == $past(req_pend)));

    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_pend && !(err_valid && err_code != 3'b000))
        |=> (sts_code == 3'b000 && !sts_double && !sts_estop));
endmodule

bind dma_err_monitor dem_checker #(.NUM_REQ(NUM_REQ), .ID_W(ID_W)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_stop_en (cfg_stop_en),
    .err_valid   (err_valid),
    .err_code    (err_code),
    .err_req     (err_req),
    .clr_pend    (clr_pend),
    .sts_code    (sts_code),
    .sts_req     (sts_req),
    .sts_double  (sts_double),
    .sts_estop   (sts_estop),
    .req_pend    (req_pend)
);

// File: tb/test_dma_err_monitor.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared on every falling edge,
// plus directed checks of the corner cases.
module test_dma_err_monitor;
    localparam int NR = 8;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_stop_en = 1'b0;
    logic          err_valid = 1'b0;
    logic [2:0]    err_code = '0;
    logic [IW-1:0] err_req = '0;
    logic          cmd_wr = 1'b0;
    logic [7:0]    cmd_data = '0;
    logic [NR-1:0] req_in = '0;
    logic [NR-1:0] req_ack = '0;
    logic [2:0]    sts_code;
    logic [IW-1:0] sts_req;
    logic          sts_double, sts_estop, err_irq, start_ok;
    logic [NR-1:0] req_pend;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dma_err_monitor #(.NUM_REQ(NR)) i_dma_err_monitor (
        .clk(clk), .rst_n(rst_n), .cfg_stop_en(cfg_stop_en),
        .err_valid(err_valid), .err_code(err_code), .err_req(err_req),
        .cmd_wr(cmd_wr), .cmd_data(cmd_data), .req_in(req_in), .req_ack(req_ack),
        .sts_code(sts_code), .sts_req(sts_req), .sts_double(sts_double),
        .sts_estop(sts_estop), .err_irq(err_irq), .start_ok(start_ok),
        .req_pend(req_pend)
    );

    // Reference model state
    int m_code, m_req, m_clr;
    bit m_dbl, m_stop;
    bit [NR-1:0] m_pend;

    always @(posedge clk) begin
        bit ev;
        bit [NR-1:0] eff_ack;
        ev = err_valid && (err_code != 0);
        eff_ack = m_stop ? '0 : req_ack;
        if (!rst_n) begin
            m_code = 0; m_req = 0; m_dbl = 0; m_stop = 0; m_clr = 0; m_pend = '0;
        end else begin
            m_pend = req_in | (m_pend & ~eff_ack);
            if (m_clr != 0) begin
                m_dbl = 0;
                m_stop = ev && cfg_stop_en;
                m_code = ev ? int'(err_code) : 0;
                m_req = ev ? int'(err_req) : 0;
            end else if (ev) begin
                if (m_code == 0) begin
                    m_code = err_code;
                    m_req = err_req;
                end else if (!m_dbl && int'(err_req) != m_req) begin
                    m_dbl = 1;
                end
                if (cfg_stop_en) m_stop = 1;
            end
            m_clr = (cmd_wr && cmd_data == 8'hA5) ? 1 : 0;
        end
    end

    task automatic check(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Model comparison on every falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R2 code", int'(sts_code), m_code);
            check("R2 req", int'(sts_req), m_req);
            check("R3 double", int'(sts_double), int'(m_dbl));
            check("R6 estop", int'(sts_estop), int'(m_stop));
            check("R6 start_ok", int'(start_ok), int'(!m_stop));
            check("R8 irq", int'(err_irq), int'(m_code != 0));
            check("R11 pend", int'(req_pend), int'(m_pend));
        end
    end

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        err_valid = 0; cmd_wr = 0; req_in = '0; req_ack = '0;
    endtask

    task automatic err(input int c, input int r);
        err_valid = 1; err_code = 3'(c); err_req = IW'(r);
    endtask

    task automatic wr(input int v);
        cmd_wr = 1; cmd_data = 8'(v);
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 code", int'(sts_code), 0);
        check("R1 double", int'(sts_double), 0);
        check("R1 estop", int'(sts_estop), 0);
        check("R1 irq", int'(err_irq), 0);
        check("R1 start_ok", int'(start_ok), 1);
        check("R1 pend", int'(req_pend), 0);
        rst_n = 1;
        tick();
        // R5 zero-code event
        err(0, 4); tick();
        check("R5 code", int'(sts_code), 0);
        check("R5 irq", int'(err_irq), 0);
        // R2 first error
        err(5, 3); tick();
        check("R2 code", int'(sts_code), 5);
        check("R2 req", int'(sts_req), 3);
        check("R8 irq", int'(err_irq), 1);
        // R4 same request
        err(2, 3); tick();
        check("R4 same req double", int'(sts_double), 0);
        check("R4 same req code", int'(sts_code), 5);
        // R3 different request
        err(6, 1); tick();
        check("R3 double", int'(sts_double), 1);
        check("R3 code kept", int'(sts_code), 5);
        check("R3 req kept", int'(sts_req), 3);
        // R4 later error
        err(7, 6); tick();
        check("R4 code", int'(sts_code), 5);
        check("R4 req", int'(sts_req), 3);
        check("R4 estop", int'(sts_estop), 0);
        // R9 other value has no effect
        wr(8'h11); tick(); tick();
        check("R9 other value", int'(sts_code), 5);
        // R9 clear timing
        wr(8'hA5); tick();
        check("R9 still held", int'(sts_code), 5);
        tick();
        check("R9 cleared code", int'(sts_code), 0);
        check("R9 cleared double", int'(sts_double), 0);
        check("R9 cleared irq", int'(err_irq), 0);
        // R6 stop entry
        cfg_stop_en = 1;
        req_in = 8'h01; tick();
        err(3, 2); tick();
        check("R6 estop", int'(sts_estop), 1);
        check("R6 start_ok", int'(start_ok), 0);
        // R7 acks ignored, requests latched
        req_ack = 8'h01; req_in = 8'h04; tick();
        check("R7 pend", int'(req_pend), 8'h05);
        // R10 clear with simultaneous error
        wr(8'hA5); tick();
        err(4, 1); tick();
        check("R10 code", int'(sts_code), 4);
        check("R10 req", int'(sts_req), 1);
        check("R10 double", int'(sts_double), 0);
        check("R10 estop", int'(sts_estop), 1);
        // clear with stop disabled, then R11 acknowledges
        cfg_stop_en = 0;
        wr(8'hA5); tick(); tick();
        check("R9 estop cleared", int'(sts_estop), 0);
        req_ack = 8'h05; req_in = 8'h04; tick();
        check("R11 ack vs set", int'(req_pend), 8'h04);
        // Mixed traffic
        for (int i = 0; i < 4000; i++) begin
            int sel;
            sel = $urandom_range(0, 99);
            if (sel < 8) err(0, $urandom_range(0, 7));
            else if (sel < 25) err($urandom_range(1, 7), $urandom_range(0, 7));
            if ($urandom_range(0, 99) < 5) wr(($urandom_range(0, 3) == 0) ? 8'h5A : 8'hA5);
            if ($urandom_range(0, 199) == 0) cfg_stop_en = ~cfg_stop_en;
            req_in = NR'($urandom) & NR'($urandom);
            req_ack = NR'($urandom);
            tick();
        end
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule